// File: doc/BRIEF.md
# Buffered Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. A programmable down-counter divides the system clock into a sample tick. The transmitter spends 16 ticks on each bit in normal mode and 8 ticks in fast mode. A one-entry holding register sits in front of the shift engine. Software can therefore queue the next character while the current one is still on the line, and consecutive frames follow each other without an idle gap.

The frame format is taken from static inputs. Each frame has 5 to 9 data bits, a parity bit that is absent, even or odd, and one or two stop bits. The block has two status outputs: holding-register-empty and frame-done. Each one drives an interrupt request through its own enable. Frame-done is sticky. It is cleared by a write-one strobe or by an interrupt acknowledge.

The shift engine is a state machine with the states IDLE, START, DATA, PARITY, STOP1 and STOP2, and these transitions:
- IDLE->START: the holding register is full and a tick arrives.
- START->DATA: the bit ends.
- DATA->PARITY or DATA->STOP1: the last data bit ends.
- PARITY->STOP1: the bit ends.
- STOP1->STOP2: the bit ends and two stop bits are selected.
- STOP1 or STOP2 -> START (reload): the last stop bit ends and the holding register is full.
- STOP1 or STOP2 -> IDLE (finish): the last stop bit ends and the holding register is empty.
- Any state -> IDLE: the transmitter is disabled.

Top module: `frame_tx`

## Requirements
- R1: After reset:
  - `txd` is 1.
  - `buf_empty` is 1.
  - `tx_done` is 0.
  - With both interrupt enables at 0, `irq_empty` and `irq_done` are 0.
- R2: A frame has the following layout:
  - one low start bit;
  - `data_bits` data bits, least significant bit first (a `data_bits` value below 5 counts as 5, a value above 9 counts as 9);
  - then the stop bit(s), which are high.
  The idle line is high.
- R3: `par_mode` selects the parity bit, which is inserted after the data bits:
  - 2'b00 or 2'b01: no parity bit;
  - 2'b10: even parity, equal to the XOR of the data bits;
  - 2'b11: odd parity, equal to the inverted XOR of the data bits.
- R4: When `two_stop` is 1, each frame ends with two high stop bits instead of one.
- R5: Each bit lasts (D+1)*16 clock cycles, where D is the last value written through `div_wr`. When `dbl_speed` is 1, each bit lasts (D+1)*8 cycles.
- R6: A write on `div_wr` loads the divisor and restarts the prescaler from that value. An idle transmitter only starts a frame on a prescaler tick. If the divisor and a character are written on the same edge, `txd` falls D+1 clock edges after that edge.
- R7: `buf_empty` behaves as follows:
  - It drops to 0 on the edge after an accepted write.
  - It returns to 1 when the character moves into the shift engine.
  - `irq_empty` equals `buf_empty` while `irq_empty_en` is 1.
- R8: The buffered character moves into the shift engine right at the end of the last stop bit. The next start bit begins with no gap, so consecutive frame starts are exactly one frame length apart.
- R9: `tx_done` goes to 1 when a frame's last stop bit ends and no character is waiting. It stays 1 until it is cleared. `irq_done` follows `tx_done` while `irq_done_en` is 1.
- R10: `tx_done` is cleared on the edge after a `done_clr` or `done_ack` pulse. If a clear and a frame completion fall on the same edge, the completion wins and the flag stays 1.
- R11: A data write while the holding register is full is ignored. The character is never sent, and neither flag changes.
- R12: While `tx_en` is 0:
  - `txd` is held at 1;
  - the holding register is emptied, and its content is never sent;
  - a frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| dbl_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| data_bits | input | 4 | Data bits per frame (5..9, clamped) |
| par_mode | input | 2 | Parity select (00/01 none, 10 even, 11 odd) |
| two_stop | input | 1 | 1: two stop bits |
| div_wr | input | 1 | Divisor write strobe (reloads prescaler) |
| div_val | input | 12 | Divisor value D |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 9 | Character to send |
| done_clr | input | 1 | Write-one clear of the frame-done flag |
| done_ack | input | 1 | Interrupt acknowledge for frame-done |
| irq_empty_en | input | 1 | Enable for the empty interrupt |
| irq_done_en | input | 1 | Enable for the done interrupt |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Sticky frame-done flag |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Frame-done interrupt request |

## Verification
Two events can fall on the same clock edge: a frame completing, which sets `tx_done`, and a software clear of that flag. With a divisor of 0 and fast mode, every bit lasts exactly 8 cycles. The bench can therefore count edges from the character write and pulse `done_clr` exactly on the completing edge. It then expects the flag to read 1, and to read 0 after one more clear. A second pair of events meets on one edge: the end of a stop bit and the hand-over of a waiting character. This is judged by checking that the next frame starts exactly one frame length after the previous one.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    localparam int MAX_DATA = 9;
    localparam int MIN_DATA = 5;
    localparam int BITS_W   = $clog2(MAX_DATA + 1);

    typedef enum logic [2:0] {
        TX_IDLE   = 3'd0,
        TX_START  = 3'd1,
        TX_DATA   = 3'd2,
        TX_PARITY = 3'd3,
        TX_STOP1  = 3'd4,
        TX_STOP2  = 3'd5
    } tx_state_e;

    function automatic logic [BITS_W-1:0] clamp_bits(input logic [BITS_W-1:0] b);
        if (b < BITS_W'(MIN_DATA))      return BITS_W'(MIN_DATA);
        else if (b > BITS_W'(MAX_DATA)) return BITS_W'(MAX_DATA);
        else                            return b;
    endfunction

    function automatic logic frame_parity(input logic [MAX_DATA-1:0] d,
                                          input logic [BITS_W-1:0]   nb,
                                          input logic                odd);
        logic p;
        p = odd;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (BITS_W'(i) < nb) p = p ^ d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/frame_tx_prescaler.sv
module frame_tx_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_wr) begin
            div_q <= div_val;
            cnt_q <= div_val;
        end else if (cnt_q == '0) begin
            cnt_q <= div_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/frame_tx_holding.sv
module frame_tx_holding #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!tx_en) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/frame_tx_shifter.sv
module frame_tx_shifter
    import frame_tx_pkg::*;
#(
    parameter int DW    = MAX_DATA,
    parameter int OVS_N = 16,
    parameter int OVS_D = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tick,
    input  logic              dbl_speed,
    input  logic [BITS_W-1:0] data_bits,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              buf_full,
    input  logic [DW-1:0]     buf_data,
    output logic              take,
    output logic              frame_done,
    output logic              txd
);
    localparam int OW = $clog2(OVS_N);
    localparam int IW = $clog2(DW);

    tx_state_e         state_q, state_d;
    logic [OW-1:0]     ovs_q;
    logic [IW-1:0]     bit_q;
    logic [DW-1:0]     shreg_q;
    logic              par_q;
    logic [BITS_W-1:0] nb_eff;
    logic [OW-1:0]     ovs_last;
    logic              bit_end;
    logic              last_data;
    logic              fin;

    assign nb_eff    = clamp_bits(data_bits);
    assign ovs_last  = dbl_speed ? OW'(OVS_D - 1) : OW'(OVS_N - 1);
    assign bit_end   = tick && (ovs_q == ovs_last);
    assign last_data = (BITS_W'(bit_q) == nb_eff - 1'b1);

    // next-state selection
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        fin     = 1'b0;
        if (!tx_en) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (buf_full && tick) begin
                        state_d = TX_START;
                        take    = 1'b1;
                    end
                end
                TX_START: begin
                    if (bit_end) state_d = TX_DATA;
                end
                TX_DATA: begin
                    if (bit_end && last_data)
                        state_d = par_mode[1] ? TX_PARITY : TX_STOP1;
                end
                TX_PARITY: begin
                    if (bit_end) state_d = TX_STOP1;
                end
                TX_STOP1: begin
                    if (bit_end) begin
                        if (two_stop) state_d = TX_STOP2;
                        else          fin     = 1'b1;
                    end
                end
                TX_STOP2: begin
                    if (bit_end) fin = 1'b1;
                end
                default: state_d = TX_IDLE;
            endcase
            if (fin) begin
                if (buf_full) begin
                    state_d = TX_START;
                    take    = 1'b1;
                end else begin
                    state_d = TX_IDLE;
                end
            end
        end
    end

    assign frame_done = fin && !buf_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovs_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
        end else if (take) begin
            ovs_q   <= '0;
            bit_q   <= '0;
            shreg_q <= buf_data;
            par_q   <= frame_parity(buf_data, nb_eff, par_mode[0]);
        end else if (state_q == TX_IDLE) begin
            ovs_q <= '0;
            bit_q <= '0;
        end else if (tick) begin
            ovs_q <= bit_end ? '0 : ovs_q + 1'b1;
            if (bit_end && state_q == TX_DATA) bit_q <= bit_q + 1'b1;
        end
    end

    // line output from the state
    always_comb begin
        unique case (state_q)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg_q[bit_q];
            TX_PARITY: txd = par_q;
            TX_STOP1:  txd = 1'b1;
            TX_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/frame_tx_flags.sv
module frame_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_full,
    input  logic frame_done,
    input  logic done_clr,
    input  logic done_ack,
    input  logic irq_empty_en,
    input  logic irq_done_en,
    output logic buf_empty,
    output logic tx_done,
    output logic irq_empty,
    output logic irq_done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     tx_done <= 1'b0;
        else if (frame_done)            tx_done <= 1'b1;
        else if (done_clr || done_ack)  tx_done <= 1'b0;
    end

    assign buf_empty = !buf_full;
    assign irq_empty = buf_empty && irq_empty_en;
    assign irq_done  = tx_done && irq_done_en;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int OVS_N = 16,
    parameter int OVS_D = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              dbl_speed,
    input  logic [BITS_W-1:0] data_bits,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              wr_en,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic              done_clr,
    input  logic              done_ack,
    input  logic              irq_empty_en,
    input  logic              irq_done_en,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);
    logic                tick;
    logic                take;
    logic                frame_done;
    logic                buf_full;
    logic [MAX_DATA-1:0] buf_data;

    frame_tx_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_wr  (div_wr),
        .div_val (div_val),
        .tick    (tick)
    );

    frame_tx_holding #(.DW(MAX_DATA)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (buf_full),
        .data    (buf_data)
    );

    frame_tx_shifter #(.DW(MAX_DATA), .OVS_N(OVS_N), .OVS_D(OVS_D)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .tick       (tick),
        .dbl_speed  (dbl_speed),
        .data_bits  (data_bits),
        .par_mode   (par_mode),
        .two_stop   (two_stop),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .take       (take),
        .frame_done (frame_done),
        .txd        (txd)
    );

    frame_tx_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .buf_full     (buf_full),
        .frame_done   (frame_done),
        .done_clr     (done_clr),
        .done_ack     (done_ack),
        .irq_empty_en (irq_empty_en),
        .irq_done_en  (irq_done_en),
        .buf_empty    (buf_empty),
        .tx_done      (tx_done),
        .irq_empty    (irq_empty),
        .irq_done     (irq_done)
    );
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_en,
    input logic done_clr,
    input logic done_ack,
    input logic txd,
    input logic buf_empty,
    input logic tx_done,
    input logic irq_empty,
    input logic irq_done
);
    assert_disable_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && buf_empty));

    assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en && buf_empty) |=> !buf_empty);

    assert_irq_empty_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> buf_empty);

    assert_full_write_keeps_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !buf_empty && !done_clr && !done_ack) |=> $stable(tx_done));

    assert_done_line_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> txd);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !done_clr && !done_ack) |=> tx_done);

    assert_irq_done_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> tx_done);
endmodule

bind frame_tx frame_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .wr_en     (wr_en),
    .done_clr  (done_clr),
    .done_ack  (done_ack),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .irq_empty (irq_empty),
    .irq_done  (irq_done)
);

// File: tb/frame_tx_tb.sv
module frame_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, dbl_speed = 1'b0, two_stop = 1'b0;
    logic [3:0]  data_bits = 4'd8;
    logic [1:0]  par_mode = 2'b00;
    logic        div_wr = 1'b0;
    logic [11:0] div_val = '0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        done_clr = 1'b0, done_ack = 1'b0;
    logic        irq_empty_en = 1'b0, irq_done_en = 1'b0;
    logic        txd, buf_empty, tx_done, irq_empty, irq_done;

    int errors = 0, checks = 0, cyc = 0, cfg_div = 0;
    int nfall = 0, nframes = 0;
    int fall_t [0:63];
    logic [8:0] expq [$];

    frame_tx u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d expected <150000 cycles", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int eff_bits(input logic [3:0] b);
        return (b < 5) ? 5 : (b > 9) ? 9 : int'(b);
    endfunction

    function automatic int bit_len();
        return (cfg_div + 1) * (dbl_speed ? 8 : 16);
    endfunction

    function automatic int frame_len();
        return 1 + eff_bits(data_bits) + (par_mode[1] ? 1 : 0) + (two_stop ? 2 : 1);
    endfunction

    // monitor: decodes the line and compares against the scoreboard
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin
                int L, nb;
                logic [8:0] got, exp;
                logic pb, ep, s1, s2;
                fall_t[nfall % 64] = cyc; nfall++;
                L = bit_len(); nb = eff_bits(data_bits);
                got = '0; s2 = 1'b1; pb = 1'b0;
                repeat (L/2) @(negedge clk);
                chk(txd == 1'b0, "R2 start bit", txd, 0);
                for (int i = 0; i < nb; i++) begin
                    repeat (L) @(negedge clk);
                    got[i] = txd;
                end
                if (par_mode[1]) begin repeat (L) @(negedge clk); pb = txd; end
                repeat (L) @(negedge clk); s1 = txd;
                if (two_stop) begin repeat (L) @(negedge clk); s2 = txd; end
                nframes++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R11/R12 unexpected frame", got, 0);
                end else begin
                    exp = expq.pop_front();
                    chk(got == exp, "R2/R5 data", got, exp);
                    if (par_mode[1]) begin
                        ep = (^exp) ^ par_mode[0];
                        chk(pb == ep, "R3 parity", pb, ep);
                    end
                    chk(s1 && s2, "R4 stop bits", {s1, s2}, 3);
                end
                prev = txd;
            end else begin
                prev = txd;
            end
        end
    end

    task automatic put(input logic [8:0] d, input bit expect_sent);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        if (expect_sent) expq.push_back(d & ((9'h1 << eff_bits(data_bits)) - 1));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        @(negedge clk);
        cfg_div = d; div_wr = 1'b1; div_val = 12'(d);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 5000 && !buf_empty; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !tx_done; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    initial begin
        int f0, n, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        chk(tx_done == 1'b0, "R1 tx_done", tx_done, 0);
        chk(!irq_empty && !irq_done, "R1 irqs off", {irq_empty, irq_done}, 0);
        irq_empty_en = 1'b1; irq_done_en = 1'b1;
        @(negedge clk);
        chk(irq_empty == 1'b1, "R7 irq_empty follows flag", irq_empty, 1);

        // 8N1, normal speed, D=2
        tx_en = 1'b1;
        set_div(2);
        put(9'h0A5, 1);
        chk(buf_empty == 1'b0 || expq.size() == 1, "R7 write fills", buf_empty, 0);
        wait_empty();
        chk(buf_empty && irq_empty, "R7 empty after transfer", {buf_empty, irq_empty}, 3);
        wait_done();
        chk(tx_done == 1'b1, "R9 done after frame", tx_done, 1);
        chk(irq_done == 1'b1, "R9 irq_done", irq_done, 1);
        repeat (5) @(negedge clk);
        chk(tx_done == 1'b1, "R9 done sticky", tx_done, 1);
        @(negedge clk); done_ack = 1'b1;
        @(negedge clk); done_ack = 1'b0;
        chk(tx_done == 1'b0, "R10 ack clears", tx_done, 1'b0);

        // 7E2 back-to-back, R8
        data_bits = 4'd7; par_mode = 2'b10; two_stop = 1'b1;
        f0 = nfall;
        put(9'h05A, 1);
        wait_empty();
        put(9'h033, 1);
        while (nfall < f0 + 2) @(negedge clk);
        chk(tx_done == 1'b0, "R9 no done between frames", tx_done, 0);
        n = (fall_t[(f0 + 1) % 64] - fall_t[f0 % 64]);
        chk(n == frame_len() * bit_len(), "R8 no gap", n, frame_len() * bit_len());
        wait_done();
        pulse_clr();
        chk(tx_done == 1'b0, "R10 write-one clear", tx_done, 0);

        // 9O1 double speed D=0, then clamped 5-bit
        data_bits = 4'd9; par_mode = 2'b11; two_stop = 1'b0; dbl_speed = 1'b1;
        set_div(0);
        put(9'h1FF, 1); wait_empty(); put(9'h100, 1);
        wait_done(); pulse_clr();
        data_bits = 4'd3;
        put(9'h03F, 1);
        wait_done(); pulse_clr();

        // R11 write while full, 8N1 D=20
        data_bits = 4'd8; par_mode = 2'b01; dbl_speed = 1'b0;
        set_div(20);
        put(9'h011, 1); wait_empty();
        put(9'h022, 1);
        chk(buf_empty == 1'b0, "R11 buffer full", buf_empty, 0);
        put(9'h0EE, 0);
        chk(buf_empty == 1'b0 && tx_done == 1'b0, "R11 flags unchanged", {buf_empty, tx_done}, 0);
        wait_done();
        chk(expq.size() == 0, "R11 only two frames sent", expq.size(), 0);
        pulse_clr();

        // R6 divisor write restarts prescaler
        cfg_div = 5;
        @(negedge clk);
        div_wr = 1'b1; div_val = 12'd5; wr_en = 1'b1; wr_data = 9'h0C3;
        expq.push_back(9'h0C3);
        k = 0;
        @(negedge clk); k++;
        div_wr = 1'b0; wr_en = 1'b0;
        while (txd && k < 100) begin @(negedge clk); k++; end
        chk(k == 7, "R6 reload timing", k, 7);
        wait_done(); pulse_clr();

        // R10 clear on the completing edge: D=0, fast, 8N1 -> 10 bits of 8 cycles
        dbl_speed = 1'b1; par_mode = 2'b00;
        set_div(0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 9'h03C; expq.push_back(9'h03C);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (8 * 10) @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(tx_done == 1'b1, "R10 completion beats clear", tx_done, 1);
        pulse_clr();
        chk(tx_done == 1'b0, "R10 clear after tie", tx_done, 0);

        // R12 disable discards pending data
        dbl_speed = 1'b0;
        set_div(200);
        put(9'h0AA, 0);
        repeat (5) @(negedge clk);
        chk(buf_empty == 1'b0, "R12 pending before disable", buf_empty, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(buf_empty == 1'b1, "R12 buffer discarded", buf_empty, 1);
        begin
            bit low = 1'b0;
            for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) low = 1'b1; end
            tx_en = 1'b1;
            for (int i = 0; i < 800; i++) begin @(negedge clk); if (!txd) low = 1'b1; end
            chk(!low, "R12 line held high, nothing sent", low, 0);
        end
        chk(expq.size() == 0, "R2 all frames seen", expq.size(), 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule